// File: doc/BRIEF.md
# Configuration EEPROM command controller

This block holds a 128-byte configuration store and runs host commands against it. The host writes an 8-bit data register and a command register that holds an opcode and a byte address. Single-byte operations finish at the edge that accepts them. Whole-array operations and the station-address reload step through the bytes one per clock, and a busy flag is high while they run. A one-cycle done pulse marks the end of every accepted command.

Bytes can only have bits cleared by a write, because a write stores the old byte ANDed with the data register. Erase sets bytes back to 0xFF. A write-protect latch guards every command that changes the array. Reload checks a signature in byte 0 before it copies bytes 1 to 6 into the station-address output. Reload also runs by itself after every reset.

Top module: `eeprom_cmd_ctrl`

## Requirements
- R1: A command write places the opcode in bits 30:28 and the byte address in bits 6:0. The readback shows the last accepted opcode and address in those bits, the address-loaded flag in bit 8, and zeros elsewhere. The opcodes are: 0 read, 1 write-protect on, 2 write-protect off, 3 byte write, 4 write-all, 5 byte erase, 6 erase-all, 7 reload.
- R2: The data register keeps bits 7:0 of a data write and reads back zero-extended. A read command copies the addressed byte into it at the accepting edge.
- R3: When writes are enabled, a byte write stores (old byte AND data register) at the address.
- R4: When writes are enabled, write-all applies the same AND to all 128 bytes, one byte per clock. Busy is observed high for 128 cycles after the accepting edge.
- R5: When writes are enabled, byte erase sets the addressed byte to 0xFF. Erase-all sets all 128 bytes to 0xFF, one byte per clock.
- R6: Byte write, write-all, byte erase and erase-all leave the array unchanged and start no busy period while the write-enable latch is clear. Opcode 2 sets the latch, opcode 1 clears it, and reset clears it.
- R7: Reload checks byte 0. If byte 0 is 0xA5, byte k (k = 1..6) goes to station_addr[8k-1:8k-8], the loaded flag is set, and busy lasts 7 cycles. Any other value clears the loaded flag, leaves station_addr unchanged, and busy lasts 1 cycle.
- R8: Busy is high while reset is applied. A reload starts by itself when reset is released. The array keeps its contents through reset.
- R9: While busy, command writes and data writes are ignored.
- R10: Done is high for one cycle when a command ends: at the accepting edge for single-byte commands and write-disabled commands, and at the last step for multi-cycle commands. Done is never high together with busy.
- R11: Accepting a new command keeps the loaded flag.
- R12: If a data write and a command arrive in the same cycle, the command uses the data register value from before the write. A read command that arrives in the same cycle as a data write takes priority over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word: opcode 30:28, address 6:0 |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Data word; only bits 7:0 are kept |
| cmd_rdata | output | 32 | Command readback with the loaded flag in bit 8 |
| data_rdata | output | 32 | Data register, zero-extended |
| busy | output | 1 | A multi-cycle operation is running |
| done | output | 1 | One-cycle completion pulse |
| station_addr | output | 48 | Station address from the last good reload |

## Verification
Two functions can fall in the same cycle, and each is driven on purpose.

- **Data write with a command.** A data write is sent together with a byte write, and again together with a read. The bench expects the write to use the old data value and the read result to win over the data write.
- **Command on the final walk step.** A command and a data write are sent in the exact cycle a write-all processes its last byte. The bench expects both to be dropped, because busy is still high at that edge.

A behavioural reference model predicts every output on every clock. Both cases are judged against that model and against fixed literal values.

// File: rtl/eeprom_cmd_ctrl.sv
module eeprom_cmd_ctrl #(
  parameter int ADDR_W = 7,
  parameter int SA_BYTES = 6,
  parameter logic [7:0] SIG = 8'hA5,
  parameter logic [8*SA_BYTES-1:0] INIT_STATION = 48'h0200_0000_0001,
  parameter logic [8*SA_BYTES-1:0] RESET_STATION = '0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [31:0] cmd_wdata,
  input  logic        data_we,
  input  logic [31:0] data_wdata,
  output logic [31:0] cmd_rdata,
  output logic [31:0] data_rdata,
  output logic        busy,
  output logic        done,
  output logic [8*SA_BYTES-1:0] station_addr
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int SA_W = 8 * SA_BYTES;

  localparam logic [2:0] OP_READ   = 3'd0;
  localparam logic [2:0] OP_WDIS   = 3'd1;
  localparam logic [2:0] OP_WEN    = 3'd2;
  localparam logic [2:0] OP_WRITE  = 3'd3;
  localparam logic [2:0] OP_WRALL  = 3'd4;
  localparam logic [2:0] OP_ERASE  = 3'd5;
  localparam logic [2:0] OP_ERALL  = 3'd6;
  localparam logic [2:0] OP_RELOAD = 3'd7;

  localparam logic [1:0] W_WRALL  = 2'd0;
  localparam logic [1:0] W_ERALL  = 2'd1;
  localparam logic [1:0] W_RELOAD = 2'd2;

  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'hFF;
    mem[0] = SIG;
    for (int k = 1; k <= SA_BYTES; k++) mem[k] = INIT_STATION[8*(k-1) +: 8];
  end

  logic              wen_q, busy_q, done_q, loaded_q;
  logic [2:0]        op_q;
  logic [ADDR_W-1:0] addr_q, idx_q;
  logic [7:0]        data_q;
  logic [SA_W-1:0]   station_q, stage_q;
  logic [1:0]        walk_q;

  logic unused_bits;
  assign unused_bits = ^{cmd_wdata[31], cmd_wdata[27:ADDR_W], data_wdata[31:8]};

  wire              accept    = cmd_we & ~busy_q;
  wire [2:0]        new_op    = cmd_wdata[30:28];
  wire [ADDR_W-1:0] new_addr  = cmd_wdata[ADDR_W-1:0];
  wire [7:0]        walk_byte = mem[idx_q];
  wire [7:0]        hit_byte  = mem[new_addr];

  logic              mem_we;
  logic [ADDR_W-1:0] mem_wa;
  logic [7:0]        mem_wd;

  always_comb begin
    mem_we = 1'b0;
    mem_wa = idx_q;
    mem_wd = 8'hFF;
    if (busy_q) begin
      if (walk_q == W_WRALL) begin
        mem_we = 1'b1;
        mem_wd = walk_byte & data_q;
      end else if (walk_q == W_ERALL) begin
        mem_we = 1'b1;
      end
    end else if (accept && wen_q) begin
      mem_wa = new_addr;
      if (new_op == OP_WRITE) begin
        mem_we = 1'b1;
        mem_wd = hit_byte & data_q;
      end else if (new_op == OP_ERASE) begin
        mem_we = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q     <= 1'b0;
      busy_q    <= 1'b1;
      walk_q    <= W_RELOAD;
      idx_q     <= '0;
      done_q    <= 1'b0;
      loaded_q  <= 1'b0;
      op_q      <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      station_q <= RESET_STATION;
      stage_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        idx_q <= idx_q + 1'b1;
        case (walk_q)
          W_RELOAD: begin
            if (idx_q == '0) begin
              if (walk_byte != SIG) begin
                loaded_q <= 1'b0;
                busy_q   <= 1'b0;
                done_q   <= 1'b1;
              end
            end else begin
              stage_q <= {walk_byte, stage_q[SA_W-1:8]};
              if (idx_q == ADDR_W'(SA_BYTES)) begin
                station_q <= {walk_byte, stage_q[SA_W-1:8]};
                loaded_q  <= 1'b1;
                busy_q    <= 1'b0;
                done_q    <= 1'b1;
              end
            end
          end
          default: begin
            if (idx_q == '1) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end
          end
        endcase
      end else begin
        if (accept) begin
          op_q   <= new_op;
          addr_q <= new_addr;
          done_q <= 1'b1;
          case (new_op)
            OP_READ: data_q <= hit_byte;
            OP_WDIS: wen_q  <= 1'b0;
            OP_WEN:  wen_q  <= 1'b1;
            OP_WRALL, OP_ERALL: begin
              if (wen_q) begin
                busy_q <= 1'b1;
                done_q <= 1'b0;
                idx_q  <= '0;
                walk_q <= (new_op == OP_WRALL) ? W_WRALL : W_ERALL;
              end
            end
            OP_RELOAD: begin
              busy_q <= 1'b1;
              done_q <= 1'b0;
              idx_q  <= '0;
              walk_q <= W_RELOAD;
            end
            default: ;
          endcase
        end
        if (data_we && !(accept && new_op == OP_READ)) data_q <= data_wdata[7:0];
      end
    end
  end

  always_comb begin
    cmd_rdata = '0;
    cmd_rdata[30:28] = op_q;
    cmd_rdata[8] = loaded_q;
    cmd_rdata[ADDR_W-1:0] = addr_q;
  end

  assign data_rdata   = {24'b0, data_q};
  assign busy         = busy_q;
  assign done         = done_q;
  assign station_addr = station_q;

endmodule

// File: rtl/eeprom_cmd_ctrl_chk.sv
module eeprom_cmd_ctrl_chk #(
  parameter int ADDR_W = 7,
  parameter int SA_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic [2:0]        op,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        data,
  input logic              loaded,
  input logic [SA_W-1:0]   station
);

  a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(op) && $stable(addr) && $stable(data)));

  a_r10_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r7_station_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station) |-> (loaded && done));

  a_r8_reload_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> busy);

endmodule

bind eeprom_cmd_ctrl eeprom_cmd_ctrl_chk #(.ADDR_W(ADDR_W), .SA_W(8*SA_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .done(done_q), .op(op_q),
  .addr(addr_q), .data(data_q), .loaded(loaded_q), .station(station_q)
);

// File: tb/test_eeprom_cmd_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_cmd_ctrl;
  localparam logic [47:0] STN = 48'h665544332211;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_we = 0;
  logic [31:0] cmd_wdata = 0;
  logic        data_we = 0;
  logic [31:0] data_wdata = 0;
  logic [31:0] cmd_rdata, data_rdata;
  logic        busy, done;
  logic [47:0] station_addr;

  always #5 clk = ~clk;

  eeprom_cmd_ctrl #(.INIT_STATION(STN)) i_eeprom_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .data_we(data_we), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .busy(busy), .done(done), .station_addr(station_addr)
  );

  int vectors = 0, miscompares = 0, cycles = 0;
  bit started = 0;

  // behavioural reference
  logic [7:0]  mm [128];
  logic [7:0]  sa [6];
  bit          m_wen, m_busy, m_done, m_loaded;
  int          m_kind, m_idx;
  logic [2:0]  m_op, c_op;
  logic [6:0]  m_addr, c_addr;
  logic [7:0]  m_data, m_old;
  logic [47:0] m_station;

  initial begin
    for (int i = 0; i < 128; i++) mm[i] = 8'hFF;
    mm[0] = 8'hA5;
    for (int k = 1; k <= 6; k++) mm[k] = STN[8*(k-1) +: 8];
  end

  task automatic finish_all();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (cycles > 50000) begin
      miscompares++;
      $display("FAIL R4 watchdog: cycles actual %0d expected below 50000", cycles);
      finish_all();
    end
    if (!rst_n) begin
      m_wen = 0; m_busy = 1; m_kind = 2; m_idx = 0; m_done = 0; m_loaded = 0;
      m_op = 0; m_addr = 0; m_data = 0; m_station = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_kind == 2) begin
          if (m_idx == 0) begin
            if (mm[0] != 8'hA5) begin m_loaded = 0; m_busy = 0; m_done = 1; end
          end else begin
            sa[m_idx-1] = mm[m_idx];
            if (m_idx == 6) begin
              m_station = {sa[5], sa[4], sa[3], sa[2], sa[1], sa[0]};
              m_loaded = 1; m_busy = 0; m_done = 1;
            end
          end
        end else begin
          mm[m_idx] = (m_kind == 0) ? (mm[m_idx] & m_data) : 8'hFF;
          if (m_idx == 127) begin m_busy = 0; m_done = 1; end
        end
        m_idx++;
      end else begin
        m_old = m_data;
        c_op = cmd_wdata[30:28];
        c_addr = cmd_wdata[6:0];
        if (data_we) m_data = data_wdata[7:0];
        if (cmd_we) begin
          m_op = c_op; m_addr = c_addr; m_done = 1;
          case (c_op)
            3'd0: m_data = mm[c_addr];
            3'd1: m_wen = 0;
            3'd2: m_wen = 1;
            3'd3: if (m_wen) mm[c_addr] = mm[c_addr] & m_old;
            3'd5: if (m_wen) mm[c_addr] = 8'hFF;
            3'd4, 3'd6: if (m_wen) begin
              m_busy = 1; m_done = 0; m_idx = 0; m_kind = (c_op == 3'd4) ? 0 : 1;
            end
            default: begin m_busy = 1; m_done = 0; m_idx = 0; m_kind = 2; end
          endcase
        end
      end
    end
  end

  task automatic cmp(input string tag, input logic [47:0] act, input logic [47:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      cmp("R4 busy", 48'(busy), 48'(m_busy));
      cmp("R10 done", 48'(done), 48'(m_done));
      cmp("R1 cmd readback", 48'(cmd_rdata), 48'({1'b0, m_op, 19'b0, m_loaded, 1'b0, m_addr}));
      cmp("R2 data readback", 48'(data_rdata), 48'(m_data));
      cmp("R7 station", station_addr, m_station);
    end
  end

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    vectors++;
    cmp(tag, act, exp);
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [2:0] op, input logic [6:0] a);
    cmd_wdata = {1'b0, op, 21'b0, a};
    cmd_we = 1;
    tick();
    cmd_we = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
  endtask

  task automatic run(input logic [2:0] op, input logic [6:0] a);
    send(op, a);
    wait_idle();
  endtask

  task automatic setdata(input logic [7:0] v);
    data_wdata = {24'hABCDEF, v};
    data_we = 1;
    tick();
    data_we = 0;
  endtask

  int cnt;

  initial begin
    tick();
    repeat (3) tick();
    rst_n = 1;
    chk("R8 busy right after reset", 48'(busy), 48'd1);
    wait_idle();
    chk("R8 station after boot reload", station_addr, STN);
    chk("R8 loaded flag", 48'(cmd_rdata[8]), 48'd1);

    run(3'd0, 7'd3);
    chk("R2 read byte 3", 48'(data_rdata), 48'h33);

    setdata(8'h0F);
    run(3'd3, 7'd10);
    run(3'd0, 7'd10);
    chk("R6 protected write ignored", 48'(data_rdata), 48'hFF);
    send(3'd6, 7'd0);
    chk("R6 protected erase-all not busy", 48'(busy), 48'd0);
    run(3'd0, 7'd3);
    chk("R6 protected erase-all ignored", 48'(data_rdata), 48'h33);

    run(3'd2, 7'd9);
    chk("R1 cmd fields", 48'(cmd_rdata), 48'h2000_0109);
    setdata(8'h3C);
    run(3'd3, 7'd10);
    run(3'd0, 7'd10);
    chk("R3 write FF and 3C", 48'(data_rdata), 48'h3C);
    setdata(8'hF0);
    run(3'd3, 7'd10);
    run(3'd0, 7'd10);
    chk("R3 write 3C and F0", 48'(data_rdata), 48'h30);
    run(3'd5, 7'd10);
    run(3'd0, 7'd10);
    chk("R5 byte erase", 48'(data_rdata), 48'hFF);

    setdata(8'h55);
    cmd_wdata = {1'b0, 3'd3, 21'b0, 7'd20};
    cmd_we = 1; data_we = 1; data_wdata = 32'h0F;
    tick();
    cmd_we = 0; data_we = 0;
    run(3'd0, 7'd20);
    chk("R12 write uses old data", 48'(data_rdata), 48'h55);
    cmd_wdata = {1'b0, 3'd0, 21'b0, 7'd3};
    cmd_we = 1; data_we = 1; data_wdata = 32'h99;
    tick();
    cmd_we = 0; data_we = 0;
    chk("R12 read beats data write", 48'(data_rdata), 48'h33);
    run(3'd0, 7'd5);
    chk("R11 loaded kept on new command", 48'(cmd_rdata), 48'h0000_0105);

    setdata(8'hFE);
    send(3'd4, 7'd0);
    chk("R4 write-all busy", 48'(busy), 48'd1);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (cnt == 40 || cnt == 128) begin
        cmd_wdata = {1'b0, 3'd0, 21'b0, 7'd7};
        cmd_we = 1; data_we = 1; data_wdata = 32'h0;
      end
      tick();
      cmd_we = 0; data_we = 0;
    end
    chk("R4 write-all length", 48'(cnt), 48'd128);
    chk("R9 cmd ignored while busy", 48'(cmd_rdata), 48'h4000_0100);
    chk("R9 data ignored while busy", 48'(data_rdata), 48'hFE);
    run(3'd0, 7'd0);
    chk("R4 write-all byte 0", 48'(data_rdata), 48'hA4);
    run(3'd0, 7'd127);
    chk("R4 write-all last byte", 48'(data_rdata), 48'hFE);

    run(3'd7, 7'd0);
    chk("R7 bad signature clears flag", 48'(cmd_rdata), 48'h7000_0000);
    chk("R7 bad signature keeps station", station_addr, STN);

    run(3'd6, 7'd0);
    run(3'd0, 7'd77);
    chk("R5 erase-all", 48'(data_rdata), 48'hFF);
    setdata(8'hA5);
    run(3'd3, 7'd0);
    for (int k = 1; k <= 6; k++) begin
      setdata(8'hA0 + 8'(k));
      run(3'd3, 7'(k));
    end
    run(3'd7, 7'd0);
    chk("R7 good reload station", station_addr, 48'hA6A5A4A3A2A1);
    chk("R7 good reload flag", 48'(cmd_rdata), 48'h7000_0100);

    run(3'd1, 7'd0);
    run(3'd5, 7'd1);
    run(3'd0, 7'd1);
    chk("R6 erase after protect", 48'(data_rdata), 48'hA1);

    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    wait_idle();
    chk("R8 reload after second reset", station_addr, 48'hA6A5A4A3A2A1);
    setdata(8'h00);
    run(3'd3, 7'd2);
    run(3'd0, 7'd2);
    chk("R6 reset clears latch", 48'(data_rdata), 48'hA2);

    tick();
    finish_all();
  end
endmodule